// File: doc/BRIEF.md
# PHY Reset Sequencer

This block turns three reset requests for a 10/100 Ethernet transceiver into one ordered release. The three requests are a power-up detect, an active-low board pin, and a self-clearing bit written by software. The pin passes through a two-stage synchronizer. It must then stay low for a minimum number of reference-clock cycles before it counts as a reset, so short glitches do nothing. A power-up reset holds for a fixed count. While it holds, the pin is not looked at.

Every reset leaves through the same path. First comes a fixed exit phase in which the register file is held at its defaults. Next, the management port is declared usable. The data path is released last, when the transmit and receive clocks report valid or when a timeout forces it. A software reset goes straight into the exit phase and skips pin qualification.

Top module: `phy_rst_seq`

## Requirements
- R1: A reset starts from the pin only when `rst_pin_n` is sampled low for at least `MIN_LOW` consecutive clock edges (default 5). A shorter low pulse leaves `regs_reset` at 0 and `reset_done` at 1.
- R2: `regs_reset` stays high while the qualified pin stays low. After the pin goes high, `mgmt_ready` rises on the (`EXIT_CYC`+3)-th clock edge: two synchronizer edges, one decision edge, then an exit phase of `EXIT_CYC` edges (default 16).
- R3: Outside the exit phase and the hold states, `regs_reset` is 0. Once `mgmt_ready` is 1, `reset_done` stays 0 until the clocks are valid or the timeout ends.
- R4: In the ready-wait stage, `reset_done` rises on the first clock edge at which `clocks_valid` is sampled high. With `clocks_valid` low, it rises `CLK_TMO` edges after `mgmt_ready` rose.
- R5: `mac_en` is 1 only while `reset_done` is 1. It rises one edge after `reset_done` rises.
- R6: While `por_det` is high, `regs_reset` is 1 and the other outputs are 0. After `por_det` falls, `mgmt_ready` rises on edge `POR_CYC`+`EXIT_CYC`.
- R7: During the power-up hold, the level of `rst_pin_n` has no effect. A low pulse that ends before the hold ends leaves the R6 timing unchanged.
- R8: A write (`ctl_wr`=1) with `ctl_wbit`=1 while `mgmt_ready` is 1 starts the exit phase at the next edge. `mgmt_ready` returns on edge `EXIT_CYC`+1. A write with `ctl_wbit`=0 has no effect.
- R9: `ctl_rbit` reads 1 for the `EXIT_CYC` cycles of a software-started exit phase and then clears itself. It reads 0 during pin and power-up resets, and writes made during those resets are ignored.
- R10: A qualified pin reset that arrives during a software exit phase takes over: it clears `ctl_rbit` and holds `regs_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_det | input | 1 | Power-up detect, active high, asynchronous |
| rst_pin_n | input | 1 | Board reset pin, active low, asynchronous to clk |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wbit | input | 1 | Value written to the reset bit of the control register |
| clocks_valid | input | 1 | Transmit and receive clocks are running |
| regs_reset | output | 1 | Forces all registers to their defaults |
| mgmt_ready | output | 1 | Management port usable |
| reset_done | output | 1 | Whole reset sequence finished |
| mac_en | output | 1 | MAC-side data interface enabled |
| ctl_rbit | output | 1 | Read-back of the self-clearing reset bit |

## Verification
A wrong state or a wrong counter value shows up directly as an edge count. The rise of `mgmt_ready` or `reset_done` moves by one or more cycles relative to the stimulus edge, so the bench measures these intervals exactly. A wrong pin qualifier shows up within a few cycles of a pulse, as a reset that fires or fails to fire. The pulse-width sweep runs on both sides of the threshold. A stuck software bit shows up as a read-back that stays high past the exit phase or appears during a pin reset.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_HOLD = 3'd1,
        ST_EXIT = 3'd2,
        ST_WAIT = 3'd3,
        ST_RUN  = 3'd4
    } rst_st_e;
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q, sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh_q <= {STAGES{RST_VAL}};
        else      sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/prs_lowqual.sv
module prs_lowqual #(
    parameter int MIN_LOW = 5
) (
    input  logic clk,
    input  logic arst,
    input  logic en,
    input  logic pin_s,
    output logic hit
);
    localparam int LW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW);
    localparam logic [LW-1:0] LAST = LW'(MIN_LOW - 1);

    logic [LW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || pin_s)       cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) cnt_q <= '0;
        else      cnt_q <= cnt_d;
    end

    assign hit = en && !pin_s && (cnt_q == LAST);

    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (arst)
        cnt_q <= LAST);
    a_r1_cnt_clears_high: assert property (@(posedge clk) disable iff (arst)
        (en && pin_s) |=> (cnt_q == '0));
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_pkg::*;
#(
    parameter int MIN_LOW  = 5,
    parameter int EXIT_CYC = 16,
    parameter int POR_CYC  = 500,
    parameter int CLK_TMO  = 1325000
) (
    input  logic clk,
    input  logic por_det,
    input  logic rst_pin_n,
    input  logic ctl_wr,
    input  logic ctl_wbit,
    input  logic clocks_valid,
    output logic regs_reset,
    output logic mgmt_ready,
    output logic reset_done,
    output logic mac_en,
    output logic ctl_rbit
);
    localparam int TMAX0 = (POR_CYC > EXIT_CYC) ? POR_CYC : EXIT_CYC;
    localparam int TMAX  = (TMAX0 > CLK_TMO) ? TMAX0 : CLK_TMO;
    localparam int CW    = $clog2(TMAX + 1);
    localparam logic [CW-1:0] POR_LAST  = CW'(POR_CYC - 1);
    localparam logic [CW-1:0] EXIT_LAST = CW'(EXIT_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(CLK_TMO - 1);

    typedef struct packed {
        rst_st_e       st;
        logic [CW-1:0] cnt;
        logic          swb;
        logic          mac;
    } seq_t;

    seq_t r_q, r_d;
    logic pin_s, qual_en, hw_hit, sw_go;

    prs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk (clk), .arst(por_det), .d(rst_pin_n), .q(pin_s)
    );

    assign qual_en = (r_q.st == ST_EXIT) || (r_q.st == ST_WAIT) || (r_q.st == ST_RUN);

    prs_lowqual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk(clk), .arst(por_det), .en(qual_en), .pin_s(pin_s), .hit(hw_hit)
    );

    assign sw_go = ctl_wr && ctl_wbit && ((r_q.st == ST_WAIT) || (r_q.st == ST_RUN));

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_POR: begin
                if (r_q.cnt == POR_LAST) begin
                    r_d.st  = ST_EXIT;
                    r_d.cnt = '0;
                end else r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_HOLD: begin
                if (pin_s) begin
                    r_d.st  = ST_EXIT;
                    r_d.cnt = '0;
                end
            end
            ST_EXIT: begin
                if (r_q.cnt == EXIT_LAST) begin
                    r_d.st  = ST_WAIT;
                    r_d.cnt = '0;
                    r_d.swb = 1'b0;
                end else r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_WAIT: begin
                if (clocks_valid || (r_q.cnt == TMO_LAST)) begin
                    r_d.st  = ST_RUN;
                    r_d.cnt = '0;
                end else r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.cnt = '0;
        endcase
        if (sw_go) begin
            r_d.st  = ST_EXIT;
            r_d.cnt = '0;
            r_d.swb = 1'b1;
        end
        if (hw_hit) begin
            r_d.st  = ST_HOLD;
            r_d.cnt = '0;
            r_d.swb = 1'b0;
        end
        r_d.mac = (r_d.st == ST_RUN) && (r_q.st == ST_RUN);
    end

    always_ff @(posedge clk or posedge por_det) begin
        if (por_det) r_q <= '{st: ST_POR, cnt: '0, swb: 1'b0, mac: 1'b0};
        else         r_q <= r_d;
    end

    assign regs_reset = (r_q.st == ST_POR) || (r_q.st == ST_HOLD) || (r_q.st == ST_EXIT);
    assign mgmt_ready = (r_q.st == ST_WAIT) || (r_q.st == ST_RUN);
    assign reset_done = (r_q.st == ST_RUN);
    assign mac_en     = r_q.mac;
    assign ctl_rbit   = r_q.swb;

    // R1: the hold state is entered only with the synchronized pin low
    a_r1_hold_needs_low: assert property (@(posedge clk) disable iff (por_det)
        (r_q.st == ST_HOLD && $past(r_q.st) != ST_HOLD) |-> $past(!pin_s));
    // R3: release happens only after the management stage
    a_r3_done_after_ready: assert property (@(posedge clk) disable iff (por_det)
        $rose(reset_done) |-> $past(mgmt_ready));
    // R4: the ready-wait counter never passes the timeout
    a_r4_tmo_bound: assert property (@(posedge clk) disable iff (por_det)
        (r_q.st == ST_WAIT) |-> (r_q.cnt <= TMO_LAST));
    // R5: the data interface never runs without completion
    a_r5_mac_needs_done: assert property (@(posedge clk) disable iff (por_det)
        mac_en |-> reset_done);
    // R7: the power-up hold never hands over to a pin hold
    a_r7_por_no_hold: assert property (@(posedge clk) disable iff (por_det)
        (r_q.st == ST_POR) |=> (r_q.st != ST_HOLD));
    // R8: an accepted software write enters reset at the next edge
    a_r8_sw_enters: assert property (@(posedge clk) disable iff (por_det)
        (ctl_wr && ctl_wbit && mgmt_ready && !hw_hit) |=> (ctl_rbit && regs_reset));
    // R9: the read-back bit is only seen inside a reset
    a_r9_rbit_in_reset: assert property (@(posedge clk) disable iff (por_det)
        ctl_rbit |-> (regs_reset && !mgmt_ready));
    // R10: a qualified pin clears the software bit
    a_r10_hw_wins: assert property (@(posedge clk) disable iff (por_det)
        hw_hit |=> !ctl_rbit);
endmodule

// File: tb/phy_rst_seq_tb.sv
module phy_rst_seq_tb;
    localparam int MIN_LOW  = 5;
    localparam int EXIT_CYC = 16;
    localparam int POR_CYC  = 20;
    localparam int CLK_TMO  = 40;

    logic clk = 1'b0;
    logic por_det = 1'b1;
    logic rst_pin_n = 1'b1;
    logic ctl_wr = 1'b0, ctl_wbit = 1'b0, clocks_valid = 1'b0;
    logic regs_reset, mgmt_ready, reset_done, mac_en, ctl_rbit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    phy_rst_seq #(.MIN_LOW(MIN_LOW), .EXIT_CYC(EXIT_CYC), .POR_CYC(POR_CYC),
                  .CLK_TMO(CLK_TMO)) u_dut (
        .clk(clk), .por_det(por_det), .rst_pin_n(rst_pin_n), .ctl_wr(ctl_wr),
        .ctl_wbit(ctl_wbit), .clocks_valid(clocks_valid), .regs_reset(regs_reset),
        .mgmt_ready(mgmt_ready), .reset_done(reset_done), .mac_en(mac_en),
        .ctl_rbit(ctl_rbit)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges_to_ready(output int n);
        n = 0;
        do begin tick(); n++; end while (!mgmt_ready && n < 2000);
    endtask

    task automatic finish_seq();
        int n;
        if (!mgmt_ready) edges_to_ready(n);
        clocks_valid = 1'b1;
        tick();
        clocks_valid = 1'b0;
        tick();
    endtask

    initial begin
        int n;
        bit fired;
        // R6 reset state
        tick(); tick();
        chk(regs_reset == 1 && mgmt_ready == 0 && reset_done == 0 && mac_en == 0
            && ctl_rbit == 0, "R6 por state", {regs_reset, mgmt_ready, reset_done,
            mac_en, ctl_rbit}, 5'b10000);
        por_det = 1'b0;
        edges_to_ready(n);
        chk(n == POR_CYC + EXIT_CYC, "R6 por to ready", n, POR_CYC + EXIT_CYC);
        chk(reset_done == 0 && regs_reset == 0, "R3 ready stage", reset_done, 0);

        // R4 timeout
        n = 0;
        do begin tick(); n++; end while (!reset_done && n < 2000);
        chk(n == CLK_TMO, "R4 timeout", n, CLK_TMO);
        chk(mac_en == 0, "R5 mac lags", mac_en, 0);
        tick();
        chk(mac_en == 1, "R5 mac on", mac_en, 1);

        // R1 pulse width sweep
        for (int w = 1; w <= 8; w++) begin
            fired = 0;
            rst_pin_n = 1'b0;
            for (int i = 0; i < w; i++) begin tick(); fired |= regs_reset; end
            rst_pin_n = 1'b1;
            for (int i = 0; i < 4; i++) begin tick(); fired |= regs_reset; end
            chk(fired == (w >= MIN_LOW), $sformatf("R1 width %0d", w), fired, w >= MIN_LOW);
            if (fired) finish_seq();
            else chk(reset_done == 1, "R1 no effect", reset_done, 1);
        end

        // R2 long hold and exit timing, R9 write during pin reset ignored
        rst_pin_n = 1'b0;
        repeat (12) tick();
        chk(regs_reset == 1 && mgmt_ready == 0, "R2 held low", regs_reset, 1);
        ctl_wr = 1'b1; ctl_wbit = 1'b1;
        tick();
        ctl_wr = 1'b0; ctl_wbit = 1'b0;
        chk(ctl_rbit == 0, "R9 hw reset hides bit", ctl_rbit, 0);
        rst_pin_n = 1'b1;
        edges_to_ready(n);
        chk(n == EXIT_CYC + 3, "R2 exit edges", n, EXIT_CYC + 3);

        // R4 early release at several delays
        for (int k = 0; k < 12; k += 5) begin
            if (!reset_done && k > 0) begin end
            repeat (k) tick();
            chk(reset_done == 0, $sformatf("R3 waiting k=%0d", k), reset_done, 0);
            clocks_valid = 1'b1;
            tick();
            clocks_valid = 1'b0;
            chk(reset_done == 1, $sformatf("R4 early k=%0d", k), reset_done, 1);
            tick();
            chk(mac_en == 1, "R5 mac after early", mac_en, 1);
            if (k < 10) begin
                ctl_wr = 1'b1; ctl_wbit = 1'b1;
                tick();
                ctl_wr = 1'b0; ctl_wbit = 1'b0;
                edges_to_ready(n);
            end
        end

        // R8 write of zero ignored
        ctl_wr = 1'b1; ctl_wbit = 1'b0;
        tick();
        ctl_wr = 1'b0;
        repeat (3) tick();
        chk(regs_reset == 0 && reset_done == 1 && ctl_rbit == 0, "R8 zero write", regs_reset, 0);

        // R8/R9 software reset timing
        ctl_wr = 1'b1; ctl_wbit = 1'b1;
        tick();
        ctl_wr = 1'b0; ctl_wbit = 1'b0;
        chk(regs_reset == 1 && mac_en == 0, "R8 sw enters", regs_reset, 1);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            n += ctl_rbit;
            if (mgmt_ready) break;
            tick();
        end
        chk(n == EXIT_CYC, "R9 bit length", n, EXIT_CYC);
        chk(ctl_rbit == 0 && mgmt_ready == 1, "R9 self clear", ctl_rbit, 0);
        finish_seq();
        ctl_wr = 1'b1; ctl_wbit = 1'b1;
        tick();
        ctl_wr = 1'b0; ctl_wbit = 1'b0;
        edges_to_ready(n);
        chk(n == EXIT_CYC, "R8 sw to ready", n + 1, EXIT_CYC + 1);
        finish_seq();

        // R10 pin reset during software exit
        ctl_wr = 1'b1; ctl_wbit = 1'b1;
        tick();
        ctl_wr = 1'b0; ctl_wbit = 1'b0;
        tick(); tick();
        rst_pin_n = 1'b0;
        repeat (8) tick();
        chk(ctl_rbit == 0 && regs_reset == 1, "R10 hw wins", ctl_rbit, 0);
        repeat (20) tick();
        chk(regs_reset == 1 && mgmt_ready == 0, "R10 still held", regs_reset, 1);
        rst_pin_n = 1'b1;
        edges_to_ready(n);
        chk(n == EXIT_CYC + 3, "R10 exit edges", n, EXIT_CYC + 3);
        finish_seq();

        // R7 pin ignored during power-up hold
        por_det = 1'b1;
        tick();
        rst_pin_n = 1'b0;
        tick();
        por_det = 1'b0;
        n = 0;
        for (int i = 0; i < 10; i++) begin tick(); n++; end
        rst_pin_n = 1'b1;
        while (!mgmt_ready && n < 2000) begin tick(); n++; end
        chk(n == POR_CYC + EXIT_CYC, "R7 pin isolated", n, POR_CYC + EXIT_CYC);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule